// File: doc/BRIEF.md
# Transparent Clock Residence Corrector

This block sits in the forwarding path of an end-to-end precision-time transparent clock. Every message that leaves through the egress port is passed on unchanged, with one cycle of latency. The only exception is the correction field of the two follow-on message types.

A timed message is a Sync or a Delay_Req. When one of these arrives at ingress, the block records its ingress timestamp. When the same message later leaves at egress, the block subtracts the recorded ingress time from the egress time. The result is the time the message spent inside the clock, and it is kept in a pending table.

The stored value is not applied to the message that was timed. It is applied to that message's partner:

- the Follow_Up that belongs to a Sync;
- the Delay_Resp that belongs to a Delay_Req.

Partners are matched on sequence ID together with source port identity. Sync traffic and Delay_Req traffic use separate tables. When the partner is forwarded, the stored residence, scaled to the correction-field format, is added to its correction field. The entry is then released.

Header parsing, framing, checksum repair and the timebase are handled by surrounding logic.

Top module: `ptc_residence_corrector`

## Requirements
- R1: Each egress message with `eg_valid` high appears on the outputs exactly one clock later with `out_valid` high. Its type, sequence ID and port identity are unchanged. A cycle without `eg_valid` gives `out_valid` low one clock later.
- R2: A message whose 4-bit type is anything other than Follow_Up (0x8) or Delay_Resp (0x9) leaves with its 64-bit correction field unchanged.
- R3: For a Sync (type 0x0), residence is egress timestamp minus the ingress timestamp of the Sync with the same sequence ID and port identity. A later Follow_Up (0x8) with that same key leaves with correction = incoming correction + (residence << 16), computed modulo 2^64 as a signed value.
- R4: For a Delay_Req (type 0x1), the residence is computed the same way and is added to the matching Delay_Resp (0x9). Residences from Sync are used only by Follow_Up, and residences from Delay_Req only by Delay_Resp.
- R5: A follow-on message whose sequence ID or port identity matches no pending entry leaves uncorrected.
- R6: A pending residence is consumed by the first matching follow-on message. A second follow-on with the same key leaves uncorrected.
- R7: Only ingress messages of type 0x0 or 0x1 record an ingress timestamp. A timed egress message with no recorded ingress stamp stores no residence.
- R8: Each table holds DEPTH entries per kind. An insertion into a full table replaces the least recently inserted entry, and the other entries are kept.
- R9: Synchronous active-high reset empties all tables and drives `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ing_valid | input | 1 | Ingress descriptor valid |
| ing_type | input | 4 | Ingress message type |
| ing_seq | input | 16 | Ingress sequence ID |
| ing_port_id | input | PID_W | Ingress source port identity |
| ing_ts | input | TS_W | Ingress timestamp, ns |
| eg_valid | input | 1 | Egress descriptor valid |
| eg_type | input | 4 | Egress message type |
| eg_seq | input | 16 | Egress sequence ID |
| eg_port_id | input | PID_W | Egress source port identity |
| eg_ts | input | TS_W | Egress timestamp, ns |
| eg_corr | input | 64 | Incoming correction field |
| out_valid | output | 1 | Forwarded descriptor valid |
| out_type | output | 4 | Forwarded message type |
| out_seq | output | 16 | Forwarded sequence ID |
| out_port_id | output | PID_W | Forwarded port identity |
| out_corr | output | 64 | Outgoing correction field |

## Verification
The assertions check the following on every clock:

- the one-cycle forwarding of valid, sequence ID and type;
- that non-follow-on messages and unmatched follow-on messages keep their correction field;
- that a table shrinks by exactly one entry when an entry is consumed, and stays full while it is being overwritten;
- that a full table always names a single victim;
- that reset empties the tables.

The bench scenarios cover what the assertions cannot:

- the arithmetic of the residence and its scaling, including a negative incoming correction;
- that the two message kinds stay separate;
- that a port-identity mismatch prevents correction;
- that the oldest entry is the one evicted;
- that the table contents are forgotten after reset.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int CORR_W    = 64;
  localparam int FRAC_BITS = 16;
  localparam int SEQ_W     = 16;
  localparam int TYPE_W    = 4;

  localparam logic [TYPE_W-1:0] MSG_SYNC       = 4'h0;
  localparam logic [TYPE_W-1:0] MSG_DELAY_REQ  = 4'h1;
  localparam logic [TYPE_W-1:0] MSG_FOLLOW_UP  = 4'h8;
  localparam logic [TYPE_W-1:0] MSG_DELAY_RESP = 4'h9;

  localparam int NUM_KINDS = 2;

  function automatic logic [TYPE_W-1:0] timed_type(input int kind);
    return (kind == 0) ? MSG_SYNC : MSG_DELAY_REQ;
  endfunction

  function automatic logic [TYPE_W-1:0] follow_type(input int kind);
    return (kind == 0) ? MSG_FOLLOW_UP : MSG_DELAY_RESP;
  endfunction
endpackage

// File: rtl/ptc_age_order.sv
module ptc_age_order #(
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [DEPTH-1:0] valid,
  output logic [DEPTH-1:0] oldest
);
  // elder[i][j] is set when slot i was written before slot j
  logic [DEPTH-1:0] elder [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) elder[i] <= '0;
    end else if (touch_en) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (IDX_W'(j) != touch_idx) begin
          elder[touch_idx][j] <= 1'b0;
          elder[j][touch_idx] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    oldest = valid;
    for (int i = 0; i < DEPTH; i++) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (i != j && valid[j] && !elder[i][j]) oldest[i] = 1'b0;
      end
    end
  end

  // R8: a full table always names exactly one victim
  p_single_victim_r8: assert property (@(posedge clk) disable iff (rst)
    (&valid) |-> ($countones(oldest) == 1));
endmodule

// File: rtl/ptc_match_table.sv
module ptc_match_table #(
  parameter int DEPTH  = 4,
  parameter int KEY_W  = 96,
  parameter int DATA_W = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_en,
  input  logic [KEY_W-1:0]  ins_key,
  input  logic [DATA_W-1:0] ins_data,
  input  logic              look_en,
  input  logic [KEY_W-1:0]  look_key,
  output logic              look_hit,
  output logic [DATA_W-1:0] look_data
);
  logic [DEPTH-1:0]  vld;
  logic [KEY_W-1:0]  key_q [DEPTH];
  logic [DATA_W-1:0] dat_q [DEPTH];
  logic [IDX_W-1:0]  look_idx;
  logic              same_hit;
  logic [IDX_W-1:0]  same_idx;
  logic              free_found;
  logic [IDX_W-1:0]  free_idx;
  logic [IDX_W-1:0]  old_idx;
  logic [IDX_W-1:0]  ins_idx;
  logic [DEPTH-1:0]  oldest;
  logic              consume;

  // lookup: first valid slot holding the key
  always_comb begin
    look_hit = 1'b0;
    look_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!look_hit && vld[i] && key_q[i] == look_key) begin
        look_hit = 1'b1;
        look_idx = IDX_W'(i);
      end
    end
  end

  assign look_data = dat_q[look_idx];
  assign consume   = look_en && look_hit;

  // slot choice: same key, else first free slot, else the oldest entry
  always_comb begin
    same_hit   = 1'b0;
    same_idx   = '0;
    free_found = 1'b0;
    free_idx   = '0;
    old_idx    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!same_hit && vld[i] && key_q[i] == ins_key) begin
        same_hit = 1'b1;
        same_idx = IDX_W'(i);
      end
      if (!free_found && !vld[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
      if (oldest[i]) old_idx = IDX_W'(i);
    end
  end

  assign ins_idx = same_hit ? same_idx : (free_found ? free_idx : old_idx);

  ptc_age_order #(.DEPTH(DEPTH)) age_i (
    .clk      (clk),
    .rst      (rst),
    .touch_en (ins_en),
    .touch_idx(ins_idx),
    .valid    (vld),
    .oldest   (oldest)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      if (consume) vld[look_idx] <= 1'b0;
      if (ins_en)  vld[ins_idx]  <= 1'b1;
    end
  end

  // storage with no reset, written one slot per cycle
  always_ff @(posedge clk) begin
    if (ins_en) begin
      key_q[ins_idx] <= ins_key;
      dat_q[ins_idx] <= ins_data;
    end
  end

  // R6: using an entry releases exactly one slot
  p_free_after_use_r6: assert property (@(posedge clk) disable iff (rst)
    (consume && !ins_en) |=> ($countones(vld) == $past($countones(vld)) - 1));

  // R8: overwriting a full table keeps it full
  p_full_stays_full_r8: assert property (@(posedge clk) disable iff (rst)
    ((&vld) && ins_en && !consume) |=> (&vld));

  // R8: inserting a new key into a table with room adds one entry
  p_insert_grows_r8: assert property (@(posedge clk) disable iff (rst)
    (ins_en && !consume && !same_hit && free_found)
      |=> ($countones(vld) == $past($countones(vld)) + 1));

  // R9: reset leaves the table empty
  p_reset_empty_r9: assert property (@(posedge clk) rst |=> (vld == '0));
endmodule

// File: rtl/ptc_residence_corrector.sv
module ptc_residence_corrector
  import ptc_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PID_W = 80,
  parameter int TS_W  = 64,
  localparam int KEY_W = SEQ_W + PID_W,
  localparam int RES_W = CORR_W - FRAC_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ing_valid,
  input  logic [3:0]        ing_type,
  input  logic [15:0]       ing_seq,
  input  logic [PID_W-1:0]  ing_port_id,
  input  logic [TS_W-1:0]   ing_ts,
  input  logic              eg_valid,
  input  logic [3:0]        eg_type,
  input  logic [15:0]       eg_seq,
  input  logic [PID_W-1:0]  eg_port_id,
  input  logic [TS_W-1:0]   eg_ts,
  input  logic [63:0]       eg_corr,
  output logic              out_valid,
  output logic [3:0]        out_type,
  output logic [15:0]       out_seq,
  output logic [PID_W-1:0]  out_port_id,
  output logic [63:0]       out_corr
);
  logic [NUM_KINDS-1:0] res_hit;
  logic [RES_W-1:0]     res_val [NUM_KINDS];
  logic [CORR_W-1:0]    corr_inc;
  logic                 is_follow;

  wire [KEY_W-1:0] ing_key = {ing_seq, ing_port_id};
  wire [KEY_W-1:0] eg_key  = {eg_seq, eg_port_id};

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    localparam logic [3:0] TIMED  = timed_type(k);
    localparam logic [3:0] FOLLOW = follow_type(k);

    logic            st_hit;
    logic [TS_W-1:0] st_ts;
    logic [TS_W-1:0] resid;
    logic            st_ins;
    logic            st_look;
    logic            rs_look;

    assign st_ins  = ing_valid && (ing_type == TIMED);
    assign st_look = eg_valid && (eg_type == TIMED);
    assign rs_look = eg_valid && (eg_type == FOLLOW);
    assign resid   = eg_ts - st_ts;

    ptc_match_table #(.DEPTH(DEPTH), .KEY_W(KEY_W), .DATA_W(TS_W)) stamp_i (
      .clk      (clk),
      .rst      (rst),
      .ins_en   (st_ins),
      .ins_key  (ing_key),
      .ins_data (ing_ts),
      .look_en  (st_look),
      .look_key (eg_key),
      .look_hit (st_hit),
      .look_data(st_ts)
    );

    ptc_match_table #(.DEPTH(DEPTH), .KEY_W(KEY_W), .DATA_W(RES_W)) resid_i (
      .clk      (clk),
      .rst      (rst),
      .ins_en   (st_look && st_hit),
      .ins_key  (eg_key),
      .ins_data (RES_W'(resid)),
      .look_en  (rs_look),
      .look_key (eg_key),
      .look_hit (res_hit[k]),
      .look_data(res_val[k])
    );
  end

  assign is_follow = (eg_type == MSG_FOLLOW_UP) || (eg_type == MSG_DELAY_RESP);

  always_comb begin
    corr_inc = '0;
    for (int k = 0; k < NUM_KINDS; k++) begin
      if (res_hit[k] && eg_type == follow_type(k))
        corr_inc = {res_val[k], {FRAC_BITS{1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= eg_valid;
  end

  always_ff @(posedge clk) begin
    out_type    <= eg_type;
    out_seq     <= eg_seq;
    out_port_id <= eg_port_id;
    out_corr    <= eg_corr + corr_inc;
  end

  // R1: forwarding takes exactly one cycle
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
    eg_valid |=> out_valid);
  p_idle_follows_r1: assert property (@(posedge clk) disable iff (rst)
    !eg_valid |=> !out_valid);
  p_seq_kept_r1: assert property (@(posedge clk) disable iff (rst)
    eg_valid |=> (out_seq == $past(eg_seq) && out_type == $past(eg_type)));

  // R2: only follow-on messages may change the correction field
  p_corr_untouched_r2: assert property (@(posedge clk) disable iff (rst)
    (eg_valid && !is_follow) |=> (out_corr == $past(eg_corr)));

  // R5: a follow-on message without a pending entry is not corrected
  p_unmatched_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (eg_valid && is_follow && res_hit == '0) |=> (out_corr == $past(eg_corr)));
endmodule

// File: tb/ptc_residence_corrector_tb.sv
module ptc_residence_corrector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int PID_W = 80;
  localparam int TS_W  = 64;

  typedef struct packed {
    logic        iv;
    logic [3:0]  it;
    logic [15:0] is;
    logic [1:0]  ip;
    logic [63:0] its;
    logic        ev;
    logic [3:0]  et;
    logic [15:0] es;
    logic [1:0]  ep;
    logic [63:0] ets;
    logic [63:0] ec;
    logic [63:0] xc;
  } vec_t;

  localparam int NV = 15;
  // 0x0 Sync, 0x1 Delay_Req, 0x8 Follow_Up, 0x9 Delay_Resp, 0xB other
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'h0, 16'd1, 2'd0, 64'd1000, 1'b0, 4'h0, 16'd0, 2'd0, 64'd0,    64'd0,   64'd0},
    '{1'b1, 4'h1, 16'd7, 2'd1, 64'd2000, 1'b1, 4'h0, 16'd1, 2'd0, 64'd1250, 64'd5,   64'd5},
    '{1'b0, 4'h0, 16'd0, 2'd0, 64'd0,    1'b1, 4'h8, 16'd1, 2'd0, 64'd0,    64'd100, 64'd16384100},
    '{1'b0, 4'h0, 16'd0, 2'd0, 64'd0,    1'b1, 4'h8, 16'd1, 2'd0, 64'd0,    64'd100, 64'd100},
    '{1'b0, 4'h0, 16'd0, 2'd0, 64'd0,    1'b1, 4'h1, 16'd7, 2'd1, 64'd2600, 64'd0,   64'd0},
    '{1'b0, 4'h0, 16'd0, 2'd0, 64'd0,    1'b1, 4'h8, 16'd7, 2'd1, 64'd0,    64'd0,   64'd0},
    '{1'b0, 4'h0, 16'd0, 2'd0, 64'd0,    1'b1, 4'h9, 16'd7, 2'd0, 64'd0,    64'd3,   64'd3},
    '{1'b0, 4'h0, 16'd0, 2'd0, 64'd0,    1'b1, 4'h9, 16'd7, 2'd1, 64'd0,    64'd3,   64'd39321603},
    '{1'b1, 4'h8, 16'd2, 2'd0, 64'd10,   1'b1, 4'hB, 16'd2, 2'd0, 64'd0,    64'd9,   64'd9},
    '{1'b0, 4'h0, 16'd0, 2'd0, 64'd0,    1'b1, 4'h0, 16'd2, 2'd0, 64'd50,   64'd0,   64'd0},
    '{1'b0, 4'h0, 16'd0, 2'd0, 64'd0,    1'b1, 4'h8, 16'd2, 2'd0, 64'd0,    64'd0,   64'd0},
    '{1'b1, 4'h0, 16'd3, 2'd0, 64'd5000, 1'b0, 4'h0, 16'd0, 2'd0, 64'd0,    64'd0,   64'd0},
    '{1'b0, 4'h0, 16'd0, 2'd0, 64'd0,    1'b1, 4'h0, 16'd3, 2'd0, 64'd5001, 64'd0,   64'd0},
    '{1'b0, 4'h0, 16'd0, 2'd0, 64'd0,    1'b1, 4'h8, 16'd3, 2'd0, 64'd0,
      64'hFFFF_FFFF_FFFF_FFFF, 64'd65535},
    '{1'b0, 4'h0, 16'd0, 2'd0, 64'd0,    1'b0, 4'h0, 16'd0, 2'd0, 64'd0,    64'd0,   64'd0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ing_valid = 1'b0;
  logic [3:0]        ing_type = '0;
  logic [15:0]       ing_seq = '0;
  logic [PID_W-1:0]  ing_port_id = '0;
  logic [TS_W-1:0]   ing_ts = '0;
  logic              eg_valid = 1'b0;
  logic [3:0]        eg_type = '0;
  logic [15:0]       eg_seq = '0;
  logic [PID_W-1:0]  eg_port_id = '0;
  logic [TS_W-1:0]   eg_ts = '0;
  logic [63:0]       eg_corr = '0;
  logic              out_valid;
  logic [3:0]        out_type;
  logic [15:0]       out_seq;
  logic [PID_W-1:0]  out_port_id;
  logic [63:0]       out_corr;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptc_residence_corrector #(.DEPTH(DEPTH), .PID_W(PID_W), .TS_W(TS_W)) dut_i (
    .clk(clk), .rst(rst),
    .ing_valid(ing_valid), .ing_type(ing_type), .ing_seq(ing_seq),
    .ing_port_id(ing_port_id), .ing_ts(ing_ts),
    .eg_valid(eg_valid), .eg_type(eg_type), .eg_seq(eg_seq),
    .eg_port_id(eg_port_id), .eg_ts(eg_ts), .eg_corr(eg_corr),
    .out_valid(out_valid), .out_type(out_type), .out_seq(out_seq),
    .out_port_id(out_port_id), .out_corr(out_corr)
  );

  function automatic logic [PID_W-1:0] pid_of(input logic [1:0] sel);
    return {64'h0011_2233_4455_6600 + 64'(sel), 16'd1};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive at the falling edge, sample one unit after the next rising edge
  task automatic step(input vec_t v);
    @(negedge clk);
    ing_valid = v.iv; ing_type = v.it; ing_seq = v.is;
    ing_port_id = pid_of(v.ip); ing_ts = v.its;
    eg_valid = v.ev; eg_type = v.et; eg_seq = v.es;
    eg_port_id = pid_of(v.ep); eg_ts = v.ets; eg_corr = v.ec;
    @(posedge clk);
    #1;
  endtask

  function automatic vec_t mk(input logic iv, input logic [3:0] it,
      input logic [15:0] is, input logic [63:0] its, input logic ev,
      input logic [3:0] et, input logic [15:0] es, input logic [63:0] ets,
      input logic [63:0] ec);
    return '{iv, it, is, 2'd0, its, ev, et, es, 2'd0, ets, ec, 64'd0};
  endfunction

  localparam vec_t IDLE = '0;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "out_valid in reset", 64'(out_valid), 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // vector table: R1..R7
    for (int i = 0; i < NV; i++) begin
      step(VECS[i]);
      chk("R1", "out_valid", 64'(out_valid), 64'(VECS[i].ev));
      if (VECS[i].ev) begin
        chk("R1", "out_type", 64'(out_type), 64'(VECS[i].et));
        chk("R1", "out_seq", 64'(out_seq), 64'(VECS[i].es));
        chk("R1", "out_port_id low", 64'(out_port_id[63:0]),
            64'(pid_of(VECS[i].ep)));
        chk("R3/R4/R2/R5/R6/R7", $sformatf("out_corr vec %0d", i),
            out_corr, VECS[i].xc);
      end
    end

    // R8: five Syncs into four slots evict the first one
    for (int s = 0; s < 5; s++)
      step(mk(1'b1, 4'h0, 16'(20 + s), 64'(100 * (20 + s)), 1'b0, 4'h0, 16'd0, 64'd0, 64'd0));
    step(mk(1'b0, 4'h0, 16'd0, 64'd0, 1'b1, 4'h0, 16'd20, 64'd9999, 64'd0));
    step(mk(1'b0, 4'h0, 16'd0, 64'd0, 1'b1, 4'h8, 16'd20, 64'd0, 64'd0));
    chk("R8", "evicted oldest seq20", out_corr, 64'd0);
    step(mk(1'b0, 4'h0, 16'd0, 64'd0, 1'b1, 4'h0, 16'd21, 64'd2107, 64'd0));
    step(mk(1'b0, 4'h0, 16'd0, 64'd0, 1'b1, 4'h8, 16'd21, 64'd0, 64'd0));
    chk("R8", "kept seq21", out_corr, 64'd458752);
    step(mk(1'b0, 4'h0, 16'd0, 64'd0, 1'b1, 4'h0, 16'd24, 64'd2403, 64'd0));
    step(mk(1'b0, 4'h0, 16'd0, 64'd0, 1'b1, 4'h8, 16'd24, 64'd0, 64'd0));
    chk("R8", "newest seq24", out_corr, 64'd196608);

    // R9: reset forgets a pending residence
    step(mk(1'b1, 4'h0, 16'd9, 64'd0, 1'b0, 4'h0, 16'd0, 64'd0, 64'd0));
    step(mk(1'b0, 4'h0, 16'd0, 64'd0, 1'b1, 4'h0, 16'd9, 64'd40, 64'd0));
    @(negedge clk);
    rst = 1'b1;
    eg_valid = 1'b0;
    ing_valid = 1'b0;
    @(posedge clk);
    #1;
    chk("R9", "out_valid after reset", 64'(out_valid), 64'd0);
    @(negedge clk);
    rst = 1'b0;
    step(mk(1'b0, 4'h0, 16'd0, 64'd0, 1'b1, 4'h8, 16'd9, 64'd0, 64'd7));
    chk("R9", "no correction after reset", out_corr, 64'd7);
    step(IDLE);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule